// File: doc/BRIEF.md
# Token-Driven Channel Readout Sequencer

This block is the digital control of one front-end readout chip with 128 analog channels. An external hold request freezes the sampled channel values. The block raises a hold-control output toward the sample-hold cells and keeps it high until the event has been read out or thrown away. While the chip is holding, a token arriving on the readout clock starts a serial scan. The scan presents the channel select index from 0 up to the last channel, one channel per clock, with a data-valid strobe. When the last channel has been shown, the block passes a one-cycle token to the next chip in the chain.

A fast-clear input aborts the event at any point: during the hold wait, in the middle of a scan, or in the token hand-off cycle. The block returns to idle, drops the hold control and passes no token. A token that arrives while a scan is running is ignored and sets a sticky protocol-error flag, which only reset clears.

The sequencer has four states. IDLE: nothing held. HELD: values frozen, waiting for the token. SCAN: channels being presented. PASS: the token hand-off cycle. It has these transitions:
- IDLE→HELD on a hold request.
- HELD→SCAN on a token.
- SCAN→PASS after the last channel.
- PASS→IDLE unconditionally.
- Any state→IDLE on fast-clear, which has the highest priority.

Top module: `chan_scan_seq`

## Requirements
- R1: After reset, `mux_sel`, `data_vld`, `token_out`, `hold_ctl` and `proto_err` are all 0.
- R2: A `hold_req` sampled high in IDLE (without `fast_clr`) sets `hold_ctl` to 1 from the next cycle on (state HELD).
- R3: A `token_in` sampled high while not holding (IDLE) is ignored: no scan starts, `data_vld` stays 0 and `proto_err` stays 0.
- R4: A `token_in` sampled high in HELD (without `fast_clr`) makes `data_vld` 1 with `mux_sel` = 0 in the next cycle.
- R5: During a scan, `mux_sel` rises by exactly 1 per clock from 0 to NUM_CH-1 (127 by default). `data_vld` is 1 in exactly those NUM_CH cycles and 0 in all others.
- R6: `token_out` is 1 for exactly one cycle, the cycle right after the one that presents channel NUM_CH-1. In the following cycle `hold_ctl` is 0 (state IDLE).
- R7: `fast_clr` sampled high in any state makes `data_vld`, `token_out` and `hold_ctl` 0 from the next cycle on. No `token_out` follows.
- R8: A `token_in` sampled high during a scan does not disturb the scan (the `mux_sel` sequence continues). It sets `proto_err`, which stays 1 until reset.
- R9: `hold_req` has no effect outside IDLE: the `mux_sel`/`data_vld` sequence and the release of `hold_ctl` after PASS are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_req | input | 1 | External request to freeze the channel samples |
| token_in | input | 1 | Readout token from the previous chip or controller |
| fast_clr | input | 1 | Abort the current event |
| mux_sel | output | ADDR_W (7) | Analog multiplexer channel select |
| data_vld | output | 1 | A channel is being presented this cycle |
| token_out | output | 1 | One-cycle token to the next chip |
| hold_ctl | output | 1 | Hold control to the sample-hold cells |
| proto_err | output | 1 | Sticky flag: token received during a scan |

## Verification
Every input takes effect one clock later. A hold request or token sampled at an edge shows in the outputs right after that edge, and channel k of a scan appears k+1 cycles after the token edge. The token pulse appears NUM_CH+1 cycles after the token edge. The bench drives inputs on the falling edge and compares outputs on the next falling edge, so each compare sees exactly one rising edge of effect. It sweeps a fast-clear over every channel position of a scan and also applies one in the HELD and PASS states.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_SCAN = 2'd2,
        ST_PASS = 2'd3
    } scan_state_t;

endpackage

// File: rtl/chan_scan_counter.sv
module chan_scan_counter #(
    parameter int NUM_CH = 128,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              inc,
    output logic [ADDR_W-1:0] cnt,
    output logic              at_last
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_CH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == LAST_IDX);

endmodule

// File: rtl/chan_scan_errflag.sv
module chan_scan_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/chan_scan_fsm.sv
module chan_scan_fsm
    import chan_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic token_in,
    input  logic fast_clr,
    input  logic at_last,
    output logic cnt_load,
    output logic cnt_inc,
    output logic scan_busy,
    output logic data_vld,
    output logic token_out,
    output logic hold_ctl
);

    scan_state_t state_q;
    scan_state_t state_d;

    // Next-state logic; fast-clear overrides every transition.
    always_comb begin
        state_d = state_q;
        if (fast_clr) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (hold_req) state_d = ST_HELD;
                ST_HELD: if (token_in) state_d = ST_SCAN;
                ST_SCAN: if (at_last)  state_d = ST_PASS;
                ST_PASS: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        cnt_load  = 1'b0;
        cnt_inc   = 1'b0;
        scan_busy = 1'b0;
        data_vld  = 1'b0;
        token_out = 1'b0;
        hold_ctl  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_HELD: begin
                hold_ctl = 1'b1;
                cnt_load = token_in && !fast_clr;
            end
            ST_SCAN: begin
                hold_ctl  = 1'b1;
                scan_busy = 1'b1;
                data_vld  = 1'b1;
                cnt_inc   = !at_last;
            end
            ST_PASS: begin
                hold_ctl  = 1'b1;
                token_out = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq #(
    parameter int NUM_CH = 128,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_req,
    input  logic              token_in,
    input  logic              fast_clr,
    output logic [ADDR_W-1:0] mux_sel,
    output logic              data_vld,
    output logic              token_out,
    output logic              hold_ctl,
    output logic              proto_err
);

    logic cnt_load;
    logic cnt_inc;
    logic at_last;
    logic scan_busy;

    chan_scan_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req  (hold_req),
        .token_in  (token_in),
        .fast_clr  (fast_clr),
        .at_last   (at_last),
        .cnt_load  (cnt_load),
        .cnt_inc   (cnt_inc),
        .scan_busy (scan_busy),
        .data_vld  (data_vld),
        .token_out (token_out),
        .hold_ctl  (hold_ctl)
    );

    chan_scan_counter #(
        .NUM_CH (NUM_CH)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .inc     (cnt_inc),
        .cnt     (mux_sel),
        .at_last (at_last)
    );

    chan_scan_errflag u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (scan_busy && token_in),
        .flag  (proto_err)
    );

endmodule

// File: rtl/chan_scan_seq_chk.sv
module chan_scan_seq_chk #(
    parameter int NUM_CH = 128,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_req,
    input logic              token_in,
    input logic              fast_clr,
    input logic [ADDR_W-1:0] mux_sel,
    input logic              data_vld,
    input logic              token_out,
    input logic              hold_ctl,
    input logic              proto_err
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_CH - 1);

    logic idle_now;
    logic held_now;
    assign idle_now = !hold_ctl;
    assign held_now = hold_ctl && !data_vld && !token_out;

    assert_hold_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && hold_req && !fast_clr) |=> (hold_ctl && !data_vld));

    assert_idle_token_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && token_in && !hold_req) |=> (!data_vld && !hold_ctl));

    assert_scan_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (held_now && token_in && !fast_clr) |=> (data_vld && mux_sel == '0));

    assert_sel_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && !fast_clr && mux_sel != LAST_IDX) |=>
            (data_vld && mux_sel == $past(mux_sel) + 1'b1));

    assert_vld_has_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |-> hold_ctl);

    assert_pass_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && !fast_clr && mux_sel == LAST_IDX) |=> (token_out && !data_vld));

    assert_pass_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> (!token_out && !hold_ctl));

    assert_excl_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_vld, token_out}));

    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fast_clr |=> (!hold_ctl && !data_vld && !token_out));

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && token_in) |=> proto_err);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

bind chan_scan_seq chan_scan_seq_chk #(
    .NUM_CH (NUM_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_req  (hold_req),
    .token_in  (token_in),
    .fast_clr  (fast_clr),
    .mux_sel   (mux_sel),
    .data_vld  (data_vld),
    .token_out (token_out),
    .hold_ctl  (hold_ctl),
    .proto_err (proto_err)
);

// File: tb/chan_scan_seq_bench.sv
`timescale 1ns/1ps
module chan_scan_seq_bench;

    localparam int NUM_CH = 128;
    localparam int ADDR_W = $clog2(NUM_CH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hold_req = 1'b0;
    logic              token_in = 1'b0;
    logic              fast_clr = 1'b0;
    logic [ADDR_W-1:0] mux_sel;
    logic              data_vld;
    logic              token_out;
    logic              hold_ctl;
    logic              proto_err;

    int n_vec  = 0;
    int n_fail = 0;
    int n_cyc  = 0;

    always #2.5 clk = ~clk;

    chan_scan_seq #(.NUM_CH(NUM_CH)) u_chan_scan_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req  (hold_req),
        .token_in  (token_in),
        .fast_clr  (fast_clr),
        .mux_sel   (mux_sel),
        .data_vld  (data_vld),
        .token_out (token_out),
        .hold_ctl  (hold_ctl),
        .proto_err (proto_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Outputs packed as {hold, vld, tok, err}
    function automatic int outs();
        return {28'd0, hold_ctl, data_vld, token_out, proto_err};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    // Raise hold, then token; leaves the bench at the negedge showing channel 0.
    task automatic start_scan();
        hold_req = 1'b1;
        tick();
        hold_req = 1'b0;
        token_in = 1'b1;
        tick();
        token_in = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            n_cyc++;
            if (n_cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", n_cyc, 150000);
                finish_run();
            end
        end
    end

    initial begin
        tick();
        tick();
        // R1 reset state
        check("R1 outputs", outs(), 0);
        check("R1 mux_sel", int'(mux_sel), 0);
        rst_n = 1'b1;
        tick();

        // R3 token while idle
        token_in = 1'b1;
        tick();
        token_in = 1'b0;
        check("R3 idle token", outs(), 0);
        tick();
        check("R3 idle token later", outs(), 0);

        // R2 / R4 / R5 / R6 full scan, with hold_req held high throughout (R9)
        hold_req = 1'b1;
        tick();
        check("R2 hold raised", outs(), 4'b1000);
        token_in = 1'b1;
        tick();
        token_in = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            check("R4/R5 vld", outs(), 4'b1100);
            check("R5 mux_sel", int'(mux_sel), i);
            tick();
        end
        check("R6 token pulse", outs(), 4'b1010);
        hold_req = 1'b0;
        tick();
        check("R6 R9 released", outs(), 0);
        tick();
        check("R6 no second pulse", outs(), 0);

        // R7 abort sweep over every channel
        for (int k = 0; k < NUM_CH; k++) begin
            start_scan();
            for (int i = 0; i < k; i++) begin
                check("R5 pre-abort sel", int'(mux_sel), i);
                tick();
            end
            check("R5 abort point sel", int'(mux_sel), k);
            fast_clr = 1'b1;
            tick();
            fast_clr = 1'b0;
            check("R7 aborted", outs(), 0);
            tick();
            check("R7 no token", outs(), 0);
            tick();
            check("R7 still idle", outs(), 0);
        end

        // R7 abort in HELD
        hold_req = 1'b1;
        tick();
        hold_req = 1'b0;
        fast_clr = 1'b1;
        tick();
        fast_clr = 1'b0;
        check("R7 held abort", outs(), 0);
        token_in = 1'b1;
        tick();
        token_in = 1'b0;
        check("R7 R3 token after abort", outs(), 0);

        // R7 abort in PASS
        start_scan();
        for (int i = 0; i < NUM_CH; i++) tick();
        check("R6 pass reached", outs(), 4'b1010);
        fast_clr = 1'b1;
        tick();
        fast_clr = 1'b0;
        check("R7 pass abort", outs(), 0);

        // R8 token during scan; R9 hold during scan
        start_scan();
        for (int i = 0; i < NUM_CH; i++) begin
            check("R8 R9 sel continues", int'(mux_sel), i);
            token_in = (i == 40);
            hold_req = (i == 60);
            tick();
            token_in = 1'b0;
            hold_req = 1'b0;
            if (i == 40) check("R8 err set", int'(proto_err), 1);
        end
        check("R8 pass with err", outs(), 4'b1011);
        tick();
        check("R8 sticky idle", outs(), 4'b0001);
        tick();
        check("R8 sticky", int'(proto_err), 1);

        finish_run();
    end

endmodule